// File: doc/BRIEF.md
# Four-Mode Shift Register with Shared Parallel Port

This block is a register of parameterised width (eight bits by default). On each rising clock edge it does one of four things, chosen by a two-bit mode select: keep its contents, shift toward the high end, shift toward the low end, or take in a full parallel word. Each shift direction has its own serial input. Two serial outputs, which are always driven, show the two end bits. Bit 0 is the low end and bit WIDTH-1 is the high end.

The parallel port is shared between input and output. It is modelled as three signals: an input bus, an output bus, and one drive-enable flag that a tri-state pad at the chip edge would use. The port drives only when both active-low output enables are low and the block is not loading. The register keeps working whatever the state of the port drivers.

An active-low clear sets every bit to zero. A parameter chooses at build time whether the clear acts at once (asynchronous) or at the next rising edge (synchronous). In both builds the clear wins over the selected mode. A select value that is unknown is treated as hold.

Top module: `ushr_top`

## Requirements
- R1: Mode select 2'b00 keeps the register unchanged at the clock edge. A select value that is unknown also keeps it unchanged.
- R2: Mode select 2'b01 (shift right) loads bit 0 from the shift-right serial input and loads bit i from the old bit i-1.
- R3: Mode select 2'b10 (shift left) loads bit WIDTH-1 from the shift-left serial input and loads bit i from the old bit i+1.
- R4: Mode select 2'b11 (load) captures the parallel input bus at the clock edge.
- R5: The drive-enable output is high only when both active-low output enables are low and the mode select is not 2'b11.
- R6: Shifting and loading work the same way while the port drivers are released. After the enables return, the output bus shows the contents that result.
- R7: The low serial output always equals bit 0 and the high serial output always equals bit WIDTH-1, whatever the output enables are.
- R8: In the asynchronous build (CLEAR_SYNC=0), a low clear sets the register to zero at once, with no clock edge.
- R9: In the synchronous build (CLEAR_SYNC=1), a low clear sets the register to zero only at a rising edge, and it overrides the selected mode on that edge.
- R10: The parallel output bus always shows the current register contents. After a clear it shows all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates happen on the rising edge |
| clr_n | input | 1 | Active-low clear |
| mode_sel | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_r_in | input | 1 | Serial input entering bit 0 during shift right |
| ser_l_in | input | 1 | Serial input entering bit WIDTH-1 during shift left |
| oe1_n | input | 1 | First active-low output enable of the parallel port |
| oe2_n | input | 1 | Second active-low output enable of the parallel port |
| pdata_in | input | WIDTH | Parallel port, incoming level |
| pdata_out | output | WIDTH | Parallel port, outgoing value (register contents) |
| pdata_oe | output | 1 | Drive enable for the parallel port pads |
| ser_low_out | output | 1 | Always-driven copy of bit 0 |
| ser_high_out | output | 1 | Always-driven copy of bit WIDTH-1 |

## Verification
The hardest case to reach is a clear that falls between two clock edges. This is the only point where the two builds disagree. The bench runs one instance of each build side by side, lowers the clear a short time after a falling edge, and samples both instances before the next rising edge. The asynchronous copy must already read zero, and the synchronous copy must still hold its old value. A synchronous clear that arrives together with a load select is also driven, to show that the clear takes priority. Shifting while the port drivers are released is checked through the serial outputs, and later through the output bus once the enables return.

// File: rtl/ushr_pkg.sv
package ushr_pkg;

  typedef enum logic [1:0] {
    MD_HOLD  = 2'b00,
    MD_RIGHT = 2'b01,
    MD_LEFT  = 2'b10,
    MD_LOAD  = 2'b11
  } md_e;

  // Anything that is not one of the three active codes, unknown values included, means hold.
  function automatic md_e md_decode(input logic [1:0] sel);
    case (sel)
      2'b01:   return MD_RIGHT;
      2'b10:   return MD_LEFT;
      2'b11:   return MD_LOAD;
      default: return MD_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/ushr_next.sv
module ushr_next
  import ushr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  md_e              md,
  input  logic [WIDTH-1:0] cur,
  input  logic             ser_r,
  input  logic             ser_l,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] nxt
);

  logic [WIDTH-1:0] right_v;
  logic [WIDTH-1:0] left_v;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign right_v[i] = ser_r;
    end else begin : g_lo_mid
      assign right_v[i] = cur[i-1];
    end
    if (i == WIDTH - 1) begin : g_hi
      assign left_v[i] = ser_l;
    end else begin : g_hi_mid
      assign left_v[i] = cur[i+1];
    end
  end

  always_comb begin
    case (md)
      MD_RIGHT: nxt = right_v;
      MD_LEFT:  nxt = left_v;
      MD_LOAD:  nxt = par_in;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/ushr_store.sv
module ushr_store #(
  parameter int WIDTH      = 8,
  parameter bit CLEAR_SYNC = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  if (CLEAR_SYNC) begin : g_sync_clr
    always_ff @(posedge clk) begin
      if (!clr_n) q <= '0;
      else        q <= nxt;
    end
  end else begin : g_async_clr
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q <= '0;
      else        q <= nxt;
    end
  end

endmodule

// File: rtl/ushr_port.sv
module ushr_port
  import ushr_pkg::*;
(
  input  md_e  md,
  input  logic oe1_n,
  input  logic oe2_n,
  output logic drive
);

  logic enabled;
  assign enabled = ~(oe1_n | oe2_n);
  assign drive   = enabled & (md != MD_LOAD);

endmodule

// File: rtl/ushr_top.sv
module ushr_top
  import ushr_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit CLEAR_SYNC = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode_sel,
  input  logic             ser_r_in,
  input  logic             ser_l_in,
  input  logic             oe1_n,
  input  logic             oe2_n,
  input  logic [WIDTH-1:0] pdata_in,
  output logic [WIDTH-1:0] pdata_out,
  output logic             pdata_oe,
  output logic             ser_low_out,
  output logic             ser_high_out
);

  localparam int MSB = WIDTH - 1;

  md_e              md;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] q;

  assign md = md_decode(mode_sel);

  ushr_next #(.WIDTH(WIDTH)) u_next (
    .md    (md),
    .cur   (q),
    .ser_r (ser_r_in),
    .ser_l (ser_l_in),
    .par_in(pdata_in),
    .nxt   (nxt)
  );

  ushr_store #(.WIDTH(WIDTH), .CLEAR_SYNC(CLEAR_SYNC)) u_store (
    .clk  (clk),
    .clr_n(clr_n),
    .nxt  (nxt),
    .q    (q)
  );

  ushr_port u_port (
    .md   (md),
    .oe1_n(oe1_n),
    .oe2_n(oe2_n),
    .drive(pdata_oe)
  );

  assign pdata_out    = q;
  assign ser_low_out  = q[0];
  assign ser_high_out = q[MSB];

  a_r1_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (md == MD_HOLD) |=> $stable(pdata_out));

  a_r2_shift_right: assert property (@(posedge clk) disable iff (!clr_n)
    (md == MD_RIGHT) |=> (pdata_out == {$past(pdata_out[MSB-1:0]), $past(ser_r_in)}));

  a_r3_shift_left: assert property (@(posedge clk) disable iff (!clr_n)
    (md == MD_LEFT) |=> (pdata_out == {$past(ser_l_in), $past(pdata_out[MSB:1])}));

  a_r4_load: assert property (@(posedge clk) disable iff (!clr_n)
    (md == MD_LOAD) |=> (pdata_out == $past(pdata_in)));

  a_r10_clear_zero: assert property (@(posedge clk)
    !clr_n |=> (pdata_out == '0));

  always_comb begin
    if (mode_sel == 2'b11) begin
      a_r5_load_release: assert (!pdata_oe);
    end
    if (oe1_n || oe2_n) begin
      a_r5_enable_gate: assert (!pdata_oe);
    end
  end

endmodule

// File: tb/sim_ushr_top.sv
`timescale 1ns/1ps
module sim_ushr_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic [1:0]   mode_sel = 2'b00;
  logic         ser_r_in = 1'b0;
  logic         ser_l_in = 1'b0;
  logic         oe1_n = 1'b0;
  logic         oe2_n = 1'b0;
  logic [W-1:0] pdata_in = '0;

  logic [W-1:0] a_out, s_out;
  logic         a_oe, s_oe, a_lo, a_hi, s_lo, s_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural models of the two builds: [0] asynchronous clear, [1] synchronous clear
  logic [W-1:0] mdl [2];

  always #5 clk = ~clk;

  ushr_top #(.WIDTH(W), .CLEAR_SYNC(1'b0)) u0 (
    .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel), .ser_r_in(ser_r_in),
    .ser_l_in(ser_l_in), .oe1_n(oe1_n), .oe2_n(oe2_n), .pdata_in(pdata_in),
    .pdata_out(a_out), .pdata_oe(a_oe), .ser_low_out(a_lo), .ser_high_out(a_hi)
  );

  ushr_top #(.WIDTH(W), .CLEAR_SYNC(1'b1)) u1 (
    .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel), .ser_r_in(ser_r_in),
    .ser_l_in(ser_l_in), .oe1_n(oe1_n), .oe2_n(oe2_n), .pdata_in(pdata_in),
    .pdata_out(s_out), .pdata_oe(s_oe), .ser_low_out(s_lo), .ser_high_out(s_hi)
  );

  function automatic logic [W-1:0] model_next(input logic [W-1:0] v);
    logic [W-1:0] r;
    r = v;
    if ($isunknown(mode_sel) || mode_sel == 2'b00) begin
      r = v;
    end else if (mode_sel == 2'b01) begin
      for (int i = W - 1; i > 0; i--) r[i] = v[i-1];
      r[0] = ser_r_in;
    end else if (mode_sel == 2'b10) begin
      for (int i = 0; i < W - 1; i++) r[i] = v[i+1];
      r[W-1] = ser_l_in;
    end else begin
      r = pdata_in;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!clr_n) mdl[k] = '0;
      else        mdl[k] = model_next(mdl[k]);
    end
  end

  always @(negedge clr_n) mdl[0] = '0;

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [1:0] m);
    if ($isunknown(m) || m == 2'b00) return "R1";
    if (m == 2'b01) return "R2";
    if (m == 2'b10) return "R3";
    return "R4";
  endfunction

  // Compare every output with the model, then drive the next cycle's inputs
  task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                      input logic [W-1:0] din, input logic o1, input logic o2,
                      input logic clr);
    logic exp_oe;
    @(negedge clk);
    exp_oe = !o1 && !o2 ? 1'b0 : 1'b0;
    exp_oe = (!oe1_n && !oe2_n && !(mode_sel === 2'b11)) ? 1'b1 : 1'b0;
    chk(clr_n ? {tag_of(mode_sel), "/R10"} : "R8", a_out, mdl[0]);
    chk(clr_n ? {tag_of(mode_sel), "/R10"} : "R9", s_out, mdl[1]);
    chk("R5", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, exp_oe});
    chk("R5", {{(W-1){1'b0}}, s_oe}, {{(W-1){1'b0}}, exp_oe});
    chk("R7", {{(W-2){1'b0}}, a_hi, a_lo}, {{(W-2){1'b0}}, mdl[0][W-1], mdl[0][0]});
    chk("R7", {{(W-2){1'b0}}, s_hi, s_lo}, {{(W-2){1'b0}}, mdl[1][W-1], mdl[1][0]});
    mode_sel = m; ser_r_in = sr; ser_l_in = sl; pdata_in = din;
    oe1_n = o1; oe2_n = o2; clr_n = clr;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mdl[0] = '0;
    mdl[1] = '0;
    // Reset state: clear held low (R8, R9)
    repeat (3) step(2'b00, 0, 0, '0, 0, 0, 0);
    // R4: load with the drivers released, R5
    step(2'b11, 0, 0, 8'hA5, 0, 0, 1);
    // R1: hold with known and unknown select
    step(2'b00, 1, 1, 8'hFF, 0, 0, 1);
    step(2'bxx, 1, 1, 8'h00, 0, 0, 1);
    step(2'b00, 0, 0, 8'h00, 0, 0, 1);
    // R2: shift right with a pattern
    for (int i = 0; i < W + 2; i++) step(2'b01, i[0] ^ i[2], 0, '0, 0, 0, 1);
    // R3: shift left with a pattern
    for (int i = 0; i < W + 2; i++) step(2'b10, 0, i[1], '0, 0, 0, 1);
    // R6: shift and load with the drivers disabled, then read back
    step(2'b11, 0, 0, 8'h3C, 1, 0, 1);
    step(2'b01, 1, 0, 8'h00, 0, 1, 1);
    step(2'b10, 0, 1, 8'h00, 1, 1, 1);
    step(2'b00, 0, 0, 8'h00, 0, 0, 1); // R6 readback on next compare
    step(2'b00, 0, 0, 8'h00, 0, 0, 1);
    // R9: synchronous clear at an edge overrides load
    step(2'b11, 0, 0, 8'hF0, 0, 0, 1);
    step(2'b11, 0, 0, 8'h77, 0, 0, 0);
    step(2'b00, 0, 0, 8'h00, 0, 0, 1);
    step(2'b11, 0, 0, 8'h96, 0, 0, 1);
    step(2'b00, 0, 0, 8'h00, 0, 0, 1);
    // R8 against R9: clear dropped between edges
    @(negedge clk);
    #2 clr_n = 1'b0;
    #1;
    chk("R8", a_out, '0);
    chk("R9", s_out, 8'h96);
    step(2'b00, 0, 0, 8'h00, 0, 0, 1);
    // Mixed traffic over all modes and enables
    for (int i = 0; i < 300; i++) begin
      step(2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
           1'($urandom), 1'($urandom), ($urandom % 16) != 0);
    end
    step(2'b00, 0, 0, '0, 0, 0, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule